// File: doc/BRIEF.md
# Expansion Card Address Decoder

This block turns a host bus address and a read/write direction into the chip selects of a peripheral card. The card carries a paged boot ROM, a paged buffer RAM, the register window of a floppy disk controller, and a real-time clock. The clock can be mapped over the top of the card window. The decoder is purely combinational. For the element it selects, it also forms the local address: the ROM or RAM byte address with the page bits prefixed, or the register index of the controller or the clock.

The card answers inside an 8 KiB window of the host address space. Two mask/match pairs are available, and a configuration input picks between them. Offsets from 0x1C00 upward are buffer RAM, and the controller and the clock claim small slices at the top of that range. Everything below 0x1C00 is read-only boot ROM.

The controller has one window for reads and a second window for writes. Within those windows, odd byte addresses never reach the controller chip. The odd byte of the data register raises a strobe that the card's wait-state logic uses.

Top module: `card_addr_decoder`

## Requirements
- R1: With `alt_window`=0 the card window is hit when (`host_addr` AND 0x7E000) equals 0x74000; outside it no select and no strobe is active.
- R2: With `alt_window`=1 the card window is hit when (`host_addr` AND 0x1FE000) equals 0x174000.
- R3: While `card_en`=0 every select and `data_lo_stb` stay low for any address.
- R4: With `clk_overlay`=0, a read (`rd_nwr`=1) at an even offset 0x1FF0..0x1FF6 asserts `fdc_cs`. `fdc_reg` then equals address bits [2:1]: 0 status, 1 track, 2 sector, 3 data.
- R5: With `clk_overlay`=0, a write (`rd_nwr`=0) at an even offset 0x1FF8..0x1FFE asserts `fdc_cs`, with `fdc_reg` = address bits [2:1]: 0 command, 1 track, 2 sector, 3 data. Controller offsets of the other direction do not select the controller.
- R6: With `clk_overlay`=0, `data_lo_stb` is high exactly at offset 0x1FF7 on a read and at 0x1FFF on a write. That access selects RAM, not the controller.
- R7: With `clk_overlay`=1, even offsets 0x1FE0..0x1FFE assert `rtc_cs`, with `rtc_reg` = address bits [4:1]. In that mode `fdc_cs` and `data_lo_stb` are never high.
- R8: Any offset from 0x1C00 to 0x1FFF that is not claimed by the controller or the clock asserts `ram_cs` in both directions. `ram_addr` is then {`ram_bank`, address[9:0]}.
- R9: A read below offset 0x1C00 asserts `rom_cs`, with `rom_addr` = {`rom_bank`, address[12:0]}. A write there asserts no select.
- R10: At most one select is high at a time. Exactly one is high for every enabled in-window access except a write to the ROM region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_addr | input | 21 | Host byte address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| card_en | input | 1 | Card enabled; nothing answers while low |
| clk_overlay | input | 1 | Map the clock over the top 32 bytes |
| alt_window | input | 1 | Choose the alternative window mask/match |
| rom_bank | input | 2 | ROM page bits |
| ram_bank | input | 1 | RAM page bit |
| rom_cs | output | 1 | Boot ROM select |
| ram_cs | output | 1 | Buffer RAM select |
| fdc_cs | output | 1 | Floppy controller select (even bytes) |
| rtc_cs | output | 1 | Clock select (even bytes) |
| data_lo_stb | output | 1 | Odd data-register byte strobe for wait states |
| rom_addr | output | 15 | ROM byte address {page, offset} |
| ram_addr | output | 11 | RAM byte address {page, offset[9:0]} |
| fdc_reg | output | 2 | Controller register index |
| rtc_reg | output | 4 | Clock register index |

## Verification
The RAM select and the data low-byte strobe are both high on the same access: the odd byte of the data register is stored to RAM while it also arms the wait-state strobe. The same holds for the controller select and the RAM region bounds, because the controller slice lies inside RAM and must take priority over it. The sweep reaches every offset of the window in both directions, with and without the clock overlay. For each access it judges the whole select vector against range arithmetic in the bench: RAM with the strobe at 0x1FF7 and 0x1FFF, the controller alone at even offsets, and never the controller under the overlay.

// File: rtl/cardec_pkg.sv
package cardec_pkg;

  // Card window layout (offsets inside the 8 KiB card window).
  localparam int OFF_W      = 13;
  localparam int RAM_LO_W   = 10;   // 1 KiB RAM page
  localparam int CTL_SPAN_W = 3;    // 8-byte controller slice
  localparam int CLK_SPAN_W = 5;    // 32-byte clock slice

  localparam logic [OFF_W-1:0] RAM_BASE    = 13'h1C00;
  localparam logic [OFF_W-1:0] CLK_BASE    = 13'h1FE0;
  localparam logic [OFF_W-1:0] CTL_RD_BASE = 13'h1FF0;
  localparam logic [OFF_W-1:0] CTL_WR_BASE = 13'h1FF8;

  typedef struct packed {
    logic rom;
    logic ram;
    logic ctl;
    logic clk;
  } sel_t;

  // True when off lies in the aligned block of 2**span_w bytes at base.
  function automatic logic in_block(input logic [OFF_W-1:0] off,
                                    input logic [OFF_W-1:0] base,
                                    input int unsigned      span_w);
    return (off >> span_w) == (base >> span_w);
  endfunction

  function automatic logic ctl_slice(input logic [OFF_W-1:0] off,
                                     input logic             is_read);
    return in_block(off, is_read ? CTL_RD_BASE : CTL_WR_BASE, CTL_SPAN_W);
  endfunction

  function automatic logic clk_slice(input logic [OFF_W-1:0] off);
    return in_block(off, CLK_BASE, CLK_SPAN_W);
  endfunction

  function automatic logic ram_region(input logic [OFF_W-1:0] off);
    return in_block(off, RAM_BASE, RAM_LO_W);
  endfunction

  // Odd byte of the data register: low three bits all set.
  function automatic logic data_lo_byte(input logic [OFF_W-1:0] off);
    return &off[2:0];
  endfunction

endpackage

// File: rtl/card_window_match.sv
module card_window_match #(
  parameter int                      ADDR_W = 21,
  parameter int                      NCFG   = 2,
  parameter logic [NCFG*ADDR_W-1:0]  MASKS  = '0,
  parameter logic [NCFG*ADDR_W-1:0]  VALS   = '0,
  localparam int                     CFG_W  = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  cfg_sel,
  output logic              hit
);

  logic [NCFG-1:0] match;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0] M = MASKS[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] V = VALS[g*ADDR_W +: ADDR_W];
    assign match[g] = ((addr & M) == V);
  end

  assign hit = match[cfg_sel];

endmodule

// File: rtl/card_region_decode.sv
module card_region_decode
  import cardec_pkg::*;
(
  input  logic             win_hit,
  input  logic             enable,
  input  logic             is_read,
  input  logic             overlay,
  input  logic [OFF_W-1:0] off,
  output sel_t             sel,
  output logic             dlo_stb
);

  logic live, ctl_win, clk_win, even, ram_reg, ctl_s, clk_s;

  always_comb begin
    live    = win_hit & enable;
    even    = ~off[0];
    ctl_win = ~overlay & ctl_slice(off, is_read);
    clk_win =  overlay & clk_slice(off);
    ram_reg = ram_region(off);

    ctl_s   = live & ctl_win & even;
    clk_s   = live & clk_win & even;

    sel.ctl = ctl_s;
    sel.clk = clk_s;
    sel.ram = live & ram_reg & ~ctl_s & ~clk_s;
    sel.rom = live & is_read & ~ram_reg;
    dlo_stb = live & ctl_win & data_lo_byte(off);
  end

endmodule

// File: rtl/card_local_addr.sv
module card_local_addr
  import cardec_pkg::*;
#(
  parameter  int ROM_PG_W = 2,
  parameter  int RAM_PG_W = 1,
  localparam int ROM_AW   = ROM_PG_W + OFF_W,
  localparam int RAM_AW   = RAM_PG_W + RAM_LO_W
) (
  input  logic [OFF_W-1:0]    off,
  input  logic [ROM_PG_W-1:0] rom_pg,
  input  logic [RAM_PG_W-1:0] ram_pg,
  output logic [ROM_AW-1:0]   rom_a,
  output logic [RAM_AW-1:0]   ram_a,
  output logic [1:0]          ctl_idx,
  output logic [3:0]          clk_idx
);

  assign rom_a   = {rom_pg, off};
  assign ram_a   = {ram_pg, off[RAM_LO_W-1:0]};
  assign ctl_idx = off[CTL_SPAN_W-1:1];
  assign clk_idx = off[CLK_SPAN_W-1:1];

endmodule

// File: rtl/card_addr_decoder.sv
module card_addr_decoder
  import cardec_pkg::*;
#(
  parameter  int                ADDR_W    = 21,
  parameter  int                ROM_PAGES = 4,
  parameter  int                RAM_PAGES = 2,
  parameter  logic [ADDR_W-1:0] STD_MASK  = 21'h07E000,
  parameter  logic [ADDR_W-1:0] STD_MATCH = 21'h074000,
  parameter  logic [ADDR_W-1:0] ALT_MASK  = 21'h1FE000,
  parameter  logic [ADDR_W-1:0] ALT_MATCH = 21'h174000,
  localparam int                ROM_PG_W  = $clog2(ROM_PAGES),
  localparam int                RAM_PG_W  = $clog2(RAM_PAGES),
  localparam int                ROM_AW    = ROM_PG_W + OFF_W,
  localparam int                RAM_AW    = RAM_PG_W + RAM_LO_W
) (
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                rd_nwr,
  input  logic                card_en,
  input  logic                clk_overlay,
  input  logic                alt_window,
  input  logic [ROM_PG_W-1:0] rom_bank,
  input  logic [RAM_PG_W-1:0] ram_bank,
  output logic                rom_cs,
  output logic                ram_cs,
  output logic                fdc_cs,
  output logic                rtc_cs,
  output logic                data_lo_stb,
  output logic [ROM_AW-1:0]   rom_addr,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic [1:0]          fdc_reg,
  output logic [3:0]          rtc_reg
);

  logic             win_hit;
  logic [OFF_W-1:0] off;
  sel_t             sel;

  assign off = host_addr[OFF_W-1:0];

  card_window_match #(
    .ADDR_W (ADDR_W),
    .NCFG   (2),
    .MASKS  ({ALT_MASK, STD_MASK}),
    .VALS   ({ALT_MATCH, STD_MATCH})
  ) u_win (
    .addr    (host_addr),
    .cfg_sel (alt_window),
    .hit     (win_hit)
  );

  card_region_decode u_reg (
    .win_hit (win_hit),
    .enable  (card_en),
    .is_read (rd_nwr),
    .overlay (clk_overlay),
    .off     (off),
    .sel     (sel),
    .dlo_stb (data_lo_stb)
  );

  card_local_addr #(
    .ROM_PG_W (ROM_PG_W),
    .RAM_PG_W (RAM_PG_W)
  ) u_la (
    .off     (off),
    .rom_pg  (rom_bank),
    .ram_pg  (ram_bank),
    .rom_a   (rom_addr),
    .ram_a   (ram_addr),
    .ctl_idx (fdc_reg),
    .clk_idx (rtc_reg)
  );

  assign rom_cs = sel.rom;
  assign ram_cs = sel.ram;
  assign fdc_cs = sel.ctl;
  assign rtc_cs = sel.clk;

endmodule

// File: rtl/card_addr_decoder_chk.sv
module card_addr_decoder_chk #(
  parameter int                ADDR_W    = 21,
  parameter logic [ADDR_W-1:0] STD_MASK  = 21'h07E000,
  parameter logic [ADDR_W-1:0] STD_MATCH = 21'h074000,
  parameter logic [ADDR_W-1:0] ALT_MASK  = 21'h1FE000,
  parameter logic [ADDR_W-1:0] ALT_MATCH = 21'h174000
) (
  input logic [ADDR_W-1:0] host_addr,
  input logic              rd_nwr,
  input logic              card_en,
  input logic              clk_overlay,
  input logic              alt_window,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              fdc_cs,
  input logic              rtc_cs,
  input logic              data_lo_stb
);

  logic       in_win;
  logic [3:0] sels;

  always_comb begin
    in_win = alt_window ? ((host_addr & ALT_MASK) == ALT_MATCH)
                        : ((host_addr & STD_MASK) == STD_MATCH);
    sels   = {rom_cs, ram_cs, fdc_cs, rtc_cs};

    a_r10_at_most_one: assert ($onehot0(sels))
      else $error("more than one select active");

    if (card_en && in_win && (rd_nwr || host_addr[12:0] >= 13'h1C00)) begin
      a_r10_exactly_one: assert ($countones(sels) == 1)
        else $error("in-window access without a single select");
    end

    if (!card_en || !in_win) begin
      a_r3_idle: assert (sels == 4'b0 && !data_lo_stb)
        else $error("select while card off or out of window");
    end

    if (clk_overlay) begin
      a_r7_no_ctl: assert (!fdc_cs && !data_lo_stb)
        else $error("controller active under clock overlay");
    end

    if (data_lo_stb) begin
      a_r6_strobe_ram: assert (ram_cs && !fdc_cs)
        else $error("odd data byte not routed to RAM");
    end

    if (fdc_cs || rtc_cs) begin
      a_r4_even_only: assert (!host_addr[0])
        else $error("peripheral selected on odd byte");
    end

    if (rom_cs) begin
      a_r9_rom_read: assert (rd_nwr)
        else $error("ROM selected on a write");
    end
  end

endmodule

bind card_addr_decoder card_addr_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .STD_MASK  (STD_MASK),
  .STD_MATCH (STD_MATCH),
  .ALT_MASK  (ALT_MASK),
  .ALT_MATCH (ALT_MATCH)
) u_chk (
  .host_addr   (host_addr),
  .rd_nwr      (rd_nwr),
  .card_en     (card_en),
  .clk_overlay (clk_overlay),
  .alt_window  (alt_window),
  .rom_cs      (rom_cs),
  .ram_cs      (ram_cs),
  .fdc_cs      (fdc_cs),
  .rtc_cs      (rtc_cs),
  .data_lo_stb (data_lo_stb)
);

// File: tb/card_addr_decoder_bench.sv
`timescale 1ns/1ps
module card_addr_decoder_bench;

  localparam int CLK_P    = 10;
  localparam int WDOG_MAX = 150000;

  logic        clk = 1'b0;
  logic [20:0] host_addr = '0;
  logic        rd_nwr = 1'b0, card_en = 1'b0, clk_overlay = 1'b0, alt_window = 1'b0;
  logic [1:0]  rom_bank = '0;
  logic [0:0]  ram_bank = '0;
  logic        rom_cs, ram_cs, fdc_cs, rtc_cs, data_lo_stb;
  logic [14:0] rom_addr;
  logic [10:0] ram_addr;
  logic [1:0]  fdc_reg;
  logic [3:0]  rtc_reg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cycles  = 0;

  card_addr_decoder u_card_addr_decoder (
    .host_addr(host_addr), .rd_nwr(rd_nwr), .card_en(card_en),
    .clk_overlay(clk_overlay), .alt_window(alt_window),
    .rom_bank(rom_bank), .ram_bank(ram_bank),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .fdc_cs(fdc_cs), .rtc_cs(rtc_cs),
    .data_lo_stb(data_lo_stb), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .fdc_reg(fdc_reg), .rtc_reg(rtc_reg)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic cmp(string req, string what, int act, int exp, int a);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%h actual=%0d expected=%0d", req, what, a, act, exp);
    end
  endtask

  // ctx overrides the per-output requirement tag when non-empty.
  task automatic run_vec(int a, bit rd, bit en, bit ov, bit alt, int rb, int mb, string ctx);
    int off, nsel, nexp;
    bit hit, live, e_fdc, e_rtc, e_dlo, e_ram, e_rom;
    host_addr = 21'(a); rd_nwr = rd; card_en = en; clk_overlay = ov;
    alt_window = alt; rom_bank = 2'(rb); ram_bank = 1'(mb);
    #(CLK_P/2);
    off  = a % 8192;
    hit  = alt ? ((a & 'h1FE000) == 'h174000) : ((a & 'h7E000) == 'h74000);
    live = en && hit;
    e_fdc = live && !ov && (off % 2 == 0) &&
            (rd ? (off >= 'h1FF0 && off <= 'h1FF7) : (off >= 'h1FF8));
    e_rtc = live && ov && off >= 'h1FE0 && (off % 2 == 0);
    e_dlo = live && !ov && (rd ? off == 'h1FF7 : off == 'h1FFF);
    e_ram = live && off >= 'h1C00 && !e_fdc && !e_rtc;
    e_rom = live && rd && off < 'h1C00;
    cmp(ctx != "" ? ctx : "R9", "rom_cs", int'(rom_cs), int'(e_rom), a);
    cmp(ctx != "" ? ctx : "R8", "ram_cs", int'(ram_cs), int'(e_ram), a);
    cmp(ctx != "" ? ctx : (rd ? "R4" : "R5"), "fdc_cs", int'(fdc_cs), int'(e_fdc), a);
    cmp(ctx != "" ? ctx : "R7", "rtc_cs", int'(rtc_cs), int'(e_rtc), a);
    cmp(ctx != "" ? ctx : "R6", "data_lo_stb", int'(data_lo_stb), int'(e_dlo), a);
    nsel = int'(rom_cs) + int'(ram_cs) + int'(fdc_cs) + int'(rtc_cs);
    nexp = int'(e_rom) + int'(e_ram) + int'(e_fdc) + int'(e_rtc);
    cmp("R10", "select count", nsel, nexp, a);
    if (e_rom) cmp("R9", "rom_addr", int'(rom_addr), rb * 8192 + off, a);
    if (e_ram) cmp("R8", "ram_addr", int'(ram_addr), mb * 1024 + off % 1024, a);
    if (e_fdc) cmp(rd ? "R4" : "R5", "fdc_reg", int'(fdc_reg), (off / 2) % 4, a);
    if (e_rtc) cmp("R7", "rtc_reg", int'(rtc_reg), (off / 2) % 16, a);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles >= WDOG_MAX) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WDOG_MAX);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Idle state: everything low with the card disabled (R3).
    #(CLK_P/2);
    cmp("R3", "idle selects", int'({rom_cs, ram_cs, fdc_cs, rtc_cs, data_lo_stb}), 0, 0);

    // Full sweep of the standard window (R4..R10, R1 hit side).
    for (int ov = 0; ov < 2; ov++)
      for (int rd = 0; rd < 2; rd++)
        for (int off = 0; off < 8192; off++)
          run_vec('h74000 + off, bit'(rd), 1'b1, bit'(ov), 1'b0,
                  (off / 7) % 4, (off >> 3) & 1, "");

    // Alternative window sweep (R2), reads, overlay off.
    for (int off = 0; off < 8192; off++)
      run_vec('h174000 + off, 1'b1, 1'b1, 1'b0, 1'b1, off % 4, off & 1, "R2");
    // Alternative window, controller writes.
    for (int off = 'h1FF0; off < 8192; off++)
      run_vec('h174000 + off, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1, "R2");

    // Window misses and aliases (R1, R2).
    run_vec('h76000, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, "R1");
    run_vec('h72000, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, "R1");
    run_vec('h75FF6, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, "R1");
    run_vec('h174000, 1'b1, 1'b1, 1'b0, 1'b0, 1, 0, "R1");
    run_vec('h0F4000, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, "R1");
    run_vec('h74000, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0, "R2");
    run_vec('h175FF6, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0, "R2");
    run_vec('h1F4000, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0, "R2");

    // Card disabled across the top region and some ROM (R3).
    for (int ov = 0; ov < 2; ov++)
      for (int rd = 0; rd < 2; rd++)
        for (int off = 'h1FC0; off < 8192; off++)
          run_vec('h74000 + off, bit'(rd), 1'b0, bit'(ov), 1'b0, 3, 1, "R3");
    for (int off = 0; off < 256; off++)
      run_vec('h74000 + off * 17, 1'b1, 1'b0, 1'b0, 1'b0, 2, 0, "R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule